// File: doc/BRIEF.md
# Block Word-Copy DMA Engine

This engine copies a block of 16-bit words from a source to a destination without CPU involvement. The source is a wide address: a segment number joined to a 16-bit offset, so it can reach anywhere in memory. The destination is a 14-bit word address, so it reaches only internal RAM and the peripheral register space.

Software programs the engine through four word registers. It sets the source offset, the source segment and the destination. Writing a nonzero word count then starts the copy. Software reads the count register to follow progress. The count reads zero when the copy has finished.

Toward the memory system the engine has one read port and one write port, each with a request/ready handshake. Each word is copied as one read followed by one write. A single grant input lets the engine yield the bus to the CPU. A one-cycle done pulse marks the end of the copy.

Top module: `wordmove_dma`

## Requirements
- R1: After reset, all four registers read zero, neither port requests and `xfer_done` is low.
- R2: The register at `cfg_sel` 0 is the source offset, 1 is the source segment, 2 is the word count and 3 is the destination. While the engine is idle, a write to 0, 1 or 3 is stored. The destination keeps only its low 14 bits and reads back with bits 15..14 zero.
- R3: Writing a nonzero value to the count register while idle starts a copy. Writing zero starts nothing: no request follows and the count stays zero.
- R4: Each word is read from address `{segment, offset}`, and the data returned is then written unchanged to the destination. The read and write requests are never high together, and the next read is issued only after the write has been accepted.
- R5: After each accepted write, the source and the destination both advance by one word. A carry out of the 16-bit offset increments the segment. The destination wraps modulo 2^14.
- R6: The count register reads the number of words not yet written. It drops by one on each accepted write and reads zero once the copy is complete.
- R7: While `bus_grant` is low, neither request is raised and the addresses and the count hold their values.
- R8: While a copy is in progress, writes to any of the four registers are ignored.
- R9: `xfer_done` is high for exactly one cycle, the first cycle in which the count reads zero after the last write was accepted.
- R10: A request that is not yet accepted keeps its address stable until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 offset, 1 segment, 2 count, 3 destination |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for the selected register |
| bus_grant | input | 1 | The engine may use the memory bus while this is high |
| rd_req | output | 1 | Read request |
| rd_addr | output | 22 | Read word address, `{segment, offset}` |
| rd_ready | input | 1 | Read accepted; `rd_data` is valid in the same cycle |
| rd_data | input | 16 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 14 | Write word address |
| wr_data | output | 16 | Write data |
| wr_ready | input | 1 | Write accepted |
| xfer_done | output | 1 | One-cycle pulse at the end of a copy |

## Verification
The copy is run four ways:
- A short block with both ports always ready exercises the basic read-then-write ordering.
- A block whose source crosses a 64K offset boundary, and whose destination crosses the top of the 14-bit space, separates a correct segment carry and destination wrap from plain truncation.
- A block with irregular ready patterns on both ports shows that requests hold their addresses while they wait.
- A block in which the grant is withdrawn mid-copy, and the registers are rewritten while busy, shows that nothing moves without the grant and that busy-time writes change neither the remaining count nor the addresses.

The count-zero write and the read-back of the narrow destination cover the idle register behaviour.

// File: rtl/wordmove_pkg.sv
package wordmove_pkg;

   typedef enum logic [1:0] {
      MV_IDLE  = 2'd0,
      MV_READ  = 2'd1,
      MV_WRITE = 2'd2
   } mv_state_e;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_SEG = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;
   localparam logic [1:0] SEL_DST = 2'd3;

endpackage

// File: rtl/wordmove_regs.sv
module wordmove_regs
   import wordmove_pkg::*;
#(
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 6,
   parameter int DST_W     = 14,
   parameter int CNT_W     = 16,
   parameter bit SEG_CARRY = 1'b1,
   localparam int SRC_FW   = SEG_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [OFS_W-1:0]  cfg_wdata,
   output logic [OFS_W-1:0]  cfg_rdata,
   input  logic              busy,
   input  logic              step,
   output logic              start,
   output logic              cnt_last,
   output logic [CNT_W-1:0]  cnt,
   output logic [SRC_FW-1:0] src_full,
   output logic [DST_W-1:0]  dst
);

   logic [OFS_W-1:0]  src_q;
   logic [SEG_W-1:0]  seg_q;
   logic [DST_W-1:0]  dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SRC_FW-1:0] src_nxt;
   logic              wr_ok;

   // Registers accept writes only while idle
   assign wr_ok = cfg_wr && !busy;
   assign start = wr_ok && (cfg_sel == SEL_CNT) && (CNT_W'(cfg_wdata) != '0);

   generate
      if (SEG_CARRY) begin : g_seg_carry
         assign src_nxt = {seg_q, src_q} + SRC_FW'(1);
      end else begin : g_seg_fixed
         assign src_nxt = {seg_q, src_q + OFS_W'(1)};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         seg_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
      end else if (step) begin
         {seg_q, src_q} <= src_nxt;
         dst_q          <= dst_q + DST_W'(1);
         cnt_q          <= cnt_q - CNT_W'(1);
      end else if (wr_ok) begin
         case (cfg_sel)
            SEL_SRC: src_q <= cfg_wdata;
            SEL_SEG: seg_q <= cfg_wdata[SEG_W-1:0];
            SEL_CNT: cnt_q <= CNT_W'(cfg_wdata);
            default: dst_q <= cfg_wdata[DST_W-1:0];
         endcase
      end
   end

   always_comb begin
      case (cfg_sel)
         SEL_SRC: cfg_rdata = src_q;
         SEL_SEG: cfg_rdata = OFS_W'(seg_q);
         SEL_CNT: cfg_rdata = OFS_W'(cnt_q);
         default: cfg_rdata = OFS_W'(dst_q);
      endcase
   end

   assign cnt_last = (cnt_q == CNT_W'(1));
   assign cnt      = cnt_q;
   assign src_full = {seg_q, src_q};
   assign dst      = dst_q;

   AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R6

   AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr && !step) |=> ($stable(src_q) && $stable(seg_q) && $stable(dst_q) && $stable(cnt_q))); // R8

endmodule

// File: rtl/wordmove_seq.sv
module wordmove_seq
   import wordmove_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cnt_last,
   input  logic              grant,
   output logic              rd_req,
   input  logic              rd_ready,
   input  logic [WORD_W-1:0] rd_data,
   output logic              wr_req,
   input  logic              wr_ready,
   output logic [WORD_W-1:0] wr_data,
   output logic              busy,
   output logic              step,
   output logic              done
);

   mv_state_e         state_q;
   logic [WORD_W-1:0] data_q;
   logic              done_q;
   logic              rd_take;

   assign rd_req  = grant && (state_q == MV_READ);
   assign wr_req  = grant && (state_q == MV_WRITE);
   assign rd_take = rd_req && rd_ready;
   assign step    = wr_req && wr_ready;
   assign busy    = (state_q != MV_IDLE);
   assign wr_data = data_q;
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MV_IDLE;
         data_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= step && cnt_last;
         case (state_q)
            MV_IDLE: begin
               if (start) state_q <= MV_READ;
            end
            MV_READ: begin
               if (rd_take) begin
                  data_q  <= rd_data;
                  state_q <= MV_WRITE;
               end
            end
            MV_WRITE: begin
               if (step) state_q <= cnt_last ? MV_IDLE : MV_READ;
            end
            default: state_q <= MV_IDLE;
         endcase
      end
   end

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_WRITE && !step) |=> $stable(wr_data)); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

endmodule

// File: rtl/wordmove_dma.sv
module wordmove_dma
   import wordmove_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 6,
   parameter int DST_W     = 14,
   parameter int CNT_W     = 16,
   parameter bit SEG_CARRY = 1'b1,
   localparam int SRC_FW   = SEG_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [OFS_W-1:0]  cfg_wdata,
   output logic [OFS_W-1:0]  cfg_rdata,
   input  logic              bus_grant,
   output logic              rd_req,
   output logic [SRC_FW-1:0] rd_addr,
   input  logic              rd_ready,
   input  logic [WORD_W-1:0] rd_data,
   output logic              wr_req,
   output logic [DST_W-1:0]  wr_addr,
   output logic [WORD_W-1:0] wr_data,
   input  logic              wr_ready,
   output logic              xfer_done
);

   generate
      if (DST_W > OFS_W || DST_W < 1) begin : g_bad_dst
         $error("wordmove_dma: DST_W must be 1..OFS_W");
      end
      if (SEG_W >= OFS_W || SEG_W < 1) begin : g_bad_seg
         $error("wordmove_dma: SEG_W must be 1..OFS_W-1");
      end
      if (CNT_W > OFS_W || CNT_W < 2) begin : g_bad_cnt
         $error("wordmove_dma: CNT_W must be 2..OFS_W");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("wordmove_dma: WORD_W must be positive");
      end
   endgenerate

   logic             busy;
   logic             step;
   logic             start;
   logic             cnt_last;
   logic [CNT_W-1:0] cnt;

   wordmove_regs #(
      .OFS_W     (OFS_W),
      .SEG_W     (SEG_W),
      .DST_W     (DST_W),
      .CNT_W     (CNT_W),
      .SEG_CARRY (SEG_CARRY)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .busy      (busy),
      .step      (step),
      .start     (start),
      .cnt_last  (cnt_last),
      .cnt       (cnt),
      .src_full  (rd_addr),
      .dst       (wr_addr)
   );

   wordmove_seq #(
      .WORD_W (WORD_W)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cnt_last (cnt_last),
      .grant    (bus_grant),
      .rd_req   (rd_req),
      .rd_ready (rd_ready),
      .rd_data  (rd_data),
      .wr_req   (wr_req),
      .wr_ready (wr_ready),
      .wr_data  (wr_data),
      .busy     (busy),
      .step     (step),
      .done     (xfer_done)
   );

   AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == SEL_CNT && cfg_wdata == '0 && !busy) |=> !busy); // R3

   AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cnt == '0); // R6

   AST_NO_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bus_grant) |=> ($stable(cnt) && $stable(rd_addr) && $stable(wr_addr))); // R7

   AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ready) |=> $stable(rd_addr)); // R10

   AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ready) |=> (wr_addr - $past(wr_addr)) == DST_W'(1)); // R5

   AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (cnt == '0 && !busy)); // R9

endmodule

// File: tb/test_wordmove_dma.sv
module test_wordmove_dma;

   localparam logic [1:0] R_SRC = 2'd0;
   localparam logic [1:0] R_SEG = 2'd1;
   localparam logic [1:0] R_CNT = 2'd2;
   localparam logic [1:0] R_DST = 2'd3;

   typedef struct packed {
      logic [13:0] a;
      logic [15:0] d;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        bus_grant = 1'b1;
   logic        rd_req;
   logic [21:0] rd_addr;
   logic        rd_ready = 1'b1;
   logic [15:0] rd_data;
   logic        wr_req;
   logic [13:0] wr_addr;
   logic [15:0] wr_data;
   logic        wr_ready = 1'b1;
   logic        xfer_done;

   int n_chk = 0;
   int n_fail = 0;
   int n_wr = 0;
   int cyc = 0;
   int stall_mode = 0;
   item_t exp_q[$];

   always #2 clk = ~clk;

   wordmove_dma i_wordmove_dma (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_grant(bus_grant),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .xfer_done(xfer_done)
   );

   function automatic logic [15:0] src_word(input logic [21:0] a);
      return a[15:0] ^ {a[21:16], a[9:0]} ^ 16'h5A3C;
   endfunction

   assign rd_data = src_word(rd_addr);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   // Ready pattern generator, updated away from the sampling edge
   always @(posedge clk) begin
      #1;
      cyc++;
      if (stall_mode == 0) begin
         rd_ready = 1'b1;
         wr_ready = 1'b1;
      end else begin
         rd_ready = (cyc % 3) == 2;
         wr_ready = (cyc % 4) != 0;
      end
   end

   // Monitor: pop expected writes and compare
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_req && wr_req) chk("R4 dual request", 32'd1, 32'd0);
         if (!bus_grant && (rd_req || wr_req)) chk("R7 request without grant", 32'd1, 32'd0);
         if (wr_req && wr_ready) begin
            n_wr++;
            if (exp_q.size() == 0) begin
               chk("R4 unexpected write", 32'd1, 32'd0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               chk("R5 write address", 32'(wr_addr), 32'(it.a));
               chk("R4 write data", 32'(wr_data), 32'(it.d));
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk("watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   task automatic reg_wr(input logic [1:0] sel, input logic [15:0] val);
      @(posedge clk); #1;
      cfg_sel = sel; cfg_wdata = val; cfg_wr = 1'b1;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] sel, output logic [15:0] val);
      @(posedge clk); #1;
      cfg_sel = sel;
      @(negedge clk);
      val = cfg_rdata;
   endtask

   task automatic start_copy(input logic [15:0] src, input logic [5:0] seg,
                             input logic [13:0] dst, input int n);
      reg_wr(R_SRC, src);
      reg_wr(R_SEG, 16'(seg));
      reg_wr(R_DST, 16'(dst));
      for (int i = 0; i < n; i++) begin
         item_t it;
         logic [21:0] full;
         full = {seg, src} + 22'(i);
         it.a = dst + 14'(i);
         it.d = src_word(full);
         exp_q.push_back(it);
      end
      n_wr = 0;
      reg_wr(R_CNT, 16'(n));
   endtask

   task automatic wait_done(input string tag);
      int k;
      @(posedge clk); #1;
      cfg_sel = R_CNT;
      k = 0;
      while (k < 5000) begin
         @(negedge clk);
         if (xfer_done) break;
         k++;
      end
      chk({tag, " R9 done seen"}, 32'(xfer_done), 32'd1);
      chk({tag, " R6 count zero at done"}, 32'(cfg_rdata), 32'd0);
      chk({tag, " R4 all words written"}, 32'(exp_q.size()), 32'd0);
      @(negedge clk);
      chk({tag, " R9 done one cycle"}, 32'(xfer_done), 32'd0);
   endtask

   initial begin
      logic [15:0] v;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk("R1 rd_req", 32'(rd_req), 32'd0);
      chk("R1 wr_req", 32'(wr_req), 32'd0);
      chk("R1 done", 32'(xfer_done), 32'd0);
      for (int s = 0; s < 4; s++) begin
         reg_rd(2'(s), v);
         chk("R1 register zero", 32'(v), 32'd0);
      end

      // R2: idle writes stored, destination narrow
      reg_wr(R_SRC, 16'hBEEF);
      reg_rd(R_SRC, v); chk("R2 offset", 32'(v), 32'hBEEF);
      reg_wr(R_SEG, 16'h0015);
      reg_rd(R_SEG, v); chk("R2 segment", 32'(v), 32'h0015);
      reg_wr(R_DST, 16'hFFFF);
      reg_rd(R_DST, v); chk("R2 destination 14 bits", 32'(v), 32'h3FFF);

      // R3: zero count starts nothing
      reg_wr(R_CNT, 16'h0000);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R3 no request after zero count", 32'(rd_req | wr_req), 32'd0);
      end
      reg_rd(R_CNT, v); chk("R3 count stays zero", 32'(v), 32'd0);

      // R4 R5 R6 R9: basic copy, always ready
      start_copy(16'h0100, 6'd2, 14'h0040, 5);
      wait_done("basic");
      reg_rd(R_SRC, v); chk("R5 offset advanced", 32'(v), 32'h0105);
      reg_rd(R_DST, v); chk("R5 destination advanced", 32'(v), 32'h0045);

      // R5: segment carry and destination wrap
      start_copy(16'hFFFE, 6'd3, 14'h3FFE, 4);
      wait_done("carry");
      reg_rd(R_SRC, v); chk("R5 offset after carry", 32'(v), 32'h0002);
      reg_rd(R_SEG, v); chk("R5 segment incremented", 32'(v), 32'h0004);
      reg_rd(R_DST, v); chk("R5 destination wrapped", 32'(v), 32'h0002);

      // R10: irregular ready on both ports
      stall_mode = 1;
      start_copy(16'h2000, 6'd1, 14'h1000, 7);
      wait_done("stall");

      // R7 R6 R8: grant withdrawn mid copy, busy writes ignored
      start_copy(16'h3000, 6'd5, 14'h0200, 9);
      repeat (12) @(posedge clk);
      #1 bus_grant = 1'b0;
      @(negedge clk);
      cfg_sel = R_CNT;
      @(negedge clk);
      v = cfg_rdata;
      chk("R6 remaining count mid copy", 32'(v), 32'(9 - n_wr));
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R7 count held without grant", 32'(cfg_rdata), 32'(v));
      end
      reg_wr(R_SRC, 16'h1234);
      reg_wr(R_SEG, 16'h0007);
      reg_wr(R_DST, 16'h0000);
      reg_wr(R_CNT, 16'h0033);
      reg_rd(R_CNT, v);
      chk("R8 count unchanged by busy write", 32'(v), 32'(9 - n_wr));
      @(posedge clk); #1 bus_grant = 1'b1;
      wait_done("grant");
      reg_rd(R_SRC, v); chk("R8 offset not overwritten", 32'(v), 32'h3009);
      reg_rd(R_SEG, v); chk("R8 segment not overwritten", 32'(v), 32'h0005);
      reg_rd(R_DST, v); chk("R8 destination not overwritten", 32'(v), 32'h0209);
      stall_mode = 0;

      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule